// File: doc/BRIEF.md
# Function-Coded 32-bit ALU with Condition Flags

This block is a 32-bit arithmetic and logic unit steered by a 6-bit function word. The operands `op_a` and `op_b` can each be inverted bit by bit before they reach the datapath. After that step the two operands feed two units side by side: a bitwise logic unit and a carry-select adder that takes a carry input. A result multiplexer picks one of the two outputs. Negative, zero, carry and overflow flags are produced with the result, and the zero flag comes from a zero detector on the chosen output.

The inputs are sampled on one rising clock edge. The result and the four flags appear as registered outputs right after that edge. A function code that is not in the supported set writes zero to the result and leaves every flag as it was. The surrounding datapath uses the block as its execute-stage ALU: it presents operands, a carry and a function word each cycle and reads the registered outputs back one cycle later.

Top module: `fsel_alu`

## Requirements
- R1: While `rst_n` is low at a rising edge, that edge clears `result`, `flag_n`, `flag_z`, `flag_c` and `flag_v` to 0.
- R2: The logic codes yield, at the next edge: 6'b000100 gives A AND B, 6'b001000 gives A AND NOT B, 6'b001001 gives A XOR B, and 6'b000001 gives A OR B.
- R3: The move codes yield, at the next edge: 6'b000000 gives A, 6'b000101 gives B, 6'b001010 gives NOT B, and 6'b001100 gives all zeros.
- R4: The arithmetic codes yield the low 32 bits of: A + B + cin for 6'b010110, A + NOT B + cin for 6'b011001, and NOT A + B + cin for 6'b110110.
- R5: For every supported code, `flag_n` equals bit 31 of the new result, and `flag_z` is 1 exactly when the new result is zero.
- R6: For arithmetic codes `flag_c` is the carry out of bit 31 of the adder. For logic and move codes `flag_c` keeps its previous value.
- R7: For arithmetic codes, `flag_v` is 1 when the two adder inputs (after any inversion) have equal sign bits and the sum's sign bit differs from them. For logic and move codes `flag_v` keeps its previous value.
- R8: Any 6-bit code outside the eleven listed in R2 to R4 loads a result of zero and leaves all four flags unchanged.
- R9: Inputs sampled at a rising edge produce `result` and flags that are valid right after that same edge, so the latency is one cycle and a new operation can start every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| carry_in | input | 1 | Carry into the adder's bit 0 |
| func | input | 6 | Function-select word |
| result | output | 32 | Registered ALU result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Every operation presented before a rising edge is due in full at that edge: the result and all four flags, with no extra pipeline stage. The bench drives each new set of inputs on a falling edge. It compares the outputs on the next falling edge against a behavioural model that steps once per clock. That way each comparison falls exactly one register stage after its stimulus. The model also carries the previous carry and overflow values forward. This lets it check the held flags for logic, move and unlisted codes.

// File: rtl/fsel_alu_pkg.sv
// Shared types for the function-coded ALU: the logic-function selector
// and the decoded control word that steers the datapath.
package fsel_alu_pkg;

    typedef enum logic [2:0] {
        LF_AND    = 3'd0,
        LF_OR     = 3'd1,
        LF_XOR    = 3'd2,
        LF_PASS_A = 3'd3,
        LF_PASS_B = 3'd4,
        LF_ZERO   = 3'd5
    } logic_fn_e;

    typedef struct packed {
        logic      legal;      // code is one of the supported set
        logic      inv_a;      // invert operand A before the units
        logic      inv_b;      // invert operand B before the units
        logic      use_cin;    // adder takes the external carry
        logic      sel_arith;  // result mux picks the adder
        logic_fn_e fn;         // logic-unit function
    } ctl_t;

endpackage

// File: rtl/fsel_alu_decode.sv
// Function-word decoder.
// Turns the 6-bit function code into independent control fields:
// operand inversion, logic function, carry use and output select.
// Assumes: codes outside the supported set come out with legal = 0.
module fsel_alu_decode
    import fsel_alu_pkg::*;
#(
    parameter int FS_W = 6
) (
    input  logic [FS_W-1:0] func,
    output ctl_t            ctl
);

    // Map each supported code to its control fields.
    always_comb begin
        ctl           = '0;
        ctl.fn        = LF_ZERO;
        ctl.legal     = 1'b1;
        case (func)
            6'b000100: ctl.fn = LF_AND;
            6'b001000: begin ctl.fn = LF_AND;    ctl.inv_b = 1'b1; end
            6'b001001: ctl.fn = LF_XOR;
            6'b000001: ctl.fn = LF_OR;
            6'b000000: ctl.fn = LF_PASS_A;
            6'b000101: ctl.fn = LF_PASS_B;
            6'b001010: begin ctl.fn = LF_PASS_B; ctl.inv_b = 1'b1; end
            6'b001100: ctl.fn = LF_ZERO;
            6'b010110: begin ctl.sel_arith = 1'b1; ctl.use_cin = 1'b1; end
            6'b011001: begin ctl.sel_arith = 1'b1; ctl.use_cin = 1'b1; ctl.inv_b = 1'b1; end
            6'b110110: begin ctl.sel_arith = 1'b1; ctl.use_cin = 1'b1; ctl.inv_a = 1'b1; end
            default:   ctl.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/fsel_alu_inv.sv
// Conditional operand inverter: one XOR gate per bit, all bits driven
// by a shared invert control.
// Assumes: inv is stable during the cycle in which it is used.
module fsel_alu_inv #(
    parameter int W = 32
) (
    input  logic [W-1:0] d,
    input  logic         inv,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign q[i] = d[i] ^ inv;
    end

endmodule

// File: rtl/fsel_alu_logic.sv
// Bitwise logic unit working on the already-conditioned operands.
// Assumes: fn is one of the logic_fn_e values.
module fsel_alu_logic
    import fsel_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_fn_e    fn,
    output logic [W-1:0] y
);

    // Select the bitwise function.
    always_comb begin
        case (fn)
            LF_AND:    y = a & b;
            LF_OR:     y = a | b;
            LF_XOR:    y = a ^ b;
            LF_PASS_A: y = a;
            LF_PASS_B: y = b;
            default:   y = '0;
        endcase
    end

endmodule

// File: rtl/fsel_alu_adder.sv
// Carry-select adder. Each block of BLK bits forms its sum for a carry-in
// of 0 and of 1, and the real block carry picks between the two.
// Assumes: W is a multiple of BLK.
module fsel_alu_adder #(
    parameter int W   = 32,
    parameter int BLK = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);

    localparam int NBLK = W / BLK;

    logic [NBLK:0] carry;

    assign carry[0] = cin;
    assign cout     = carry[NBLK];

    for (genvar g = 0; g < NBLK; g++) begin : g_blk
        logic [BLK:0] s0;
        logic [BLK:0] s1;
        assign s0 = {1'b0, a[g*BLK +: BLK]} + {1'b0, b[g*BLK +: BLK]};
        assign s1 = {1'b0, a[g*BLK +: BLK]} + {1'b0, b[g*BLK +: BLK]} + {{BLK{1'b0}}, 1'b1};
        assign sum[g*BLK +: BLK] = carry[g] ? s1[BLK-1:0] : s0[BLK-1:0];
        assign carry[g+1]        = carry[g] ? s1[BLK] : s0[BLK];
    end

endmodule

// File: rtl/fsel_alu.sv
// Function-coded ALU top. Decodes the function word, conditions the two
// operands, runs the logic unit and the adder side by side, muxes the
// result and registers it with N, Z, C and V on one rising edge.
// Assumes: synchronous active-low reset. Unlisted codes load zero and
// hold all flags. Logic codes hold C and V.
module fsel_alu
    import fsel_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int FS_W  = 6,
    parameter int BLK   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    input  logic [FS_W-1:0]  func,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_c,
    output logic             flag_v
);

    localparam int MSB = WIDTH - 1;

    ctl_t             ctl;
    logic [WIDTH-1:0] a_c;
    logic [WIDTH-1:0] b_c;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic [WIDTH-1:0] sel_y;
    logic             ovf;

    fsel_alu_decode #(.FS_W(FS_W)) u_dec (
        .func (func),
        .ctl  (ctl)
    );

    fsel_alu_inv #(.W(WIDTH)) u_inv_a (
        .d   (op_a),
        .inv (ctl.inv_a),
        .q   (a_c)
    );

    fsel_alu_inv #(.W(WIDTH)) u_inv_b (
        .d   (op_b),
        .inv (ctl.inv_b),
        .q   (b_c)
    );

    fsel_alu_logic #(.W(WIDTH)) u_logic (
        .a  (a_c),
        .b  (b_c),
        .fn (ctl.fn),
        .y  (logic_y)
    );

    fsel_alu_adder #(.W(WIDTH), .BLK(BLK)) u_add (
        .a    (a_c),
        .b    (b_c),
        .cin  (carry_in & ctl.use_cin),
        .sum  (sum),
        .cout (cout)
    );

    // Result mux and signed-overflow detection on the adder inputs.
    always_comb begin
        sel_y = ctl.sel_arith ? sum : logic_y;
        ovf   = (a_c[MSB] == b_c[MSB]) && (sum[MSB] != a_c[MSB]);
    end

    // Register the result and flags; hold flags for unlisted codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            flag_n <= 1'b0;
            flag_z <= 1'b0;
            flag_c <= 1'b0;
            flag_v <= 1'b0;
        end else if (ctl.legal) begin
            result <= sel_y;
            flag_n <= sel_y[MSB];
            flag_z <= (sel_y == '0);
            if (ctl.sel_arith) begin
                flag_c <= cout;
                flag_v <= ovf;
            end
        end else begin
            result <= '0;
        end
    end

endmodule

// File: rtl/fsel_alu_checker.sv
// Property checker for fsel_alu. It holds its own list of supported codes
// and relates the function input to the registered outputs one edge later.
// Assumes: bound to every fsel_alu instance.
module fsel_alu_checker #(
    parameter int WIDTH = 32,
    parameter int FS_W  = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [FS_W-1:0]  func,
    input logic [WIDTH-1:0] result,
    input logic             flag_n,
    input logic             flag_z,
    input logic             flag_c,
    input logic             flag_v
);

    logic is_logic;
    logic is_arith;
    logic is_listed;

    // Classify the presented code independently of the decoder.
    always_comb begin
        is_logic  = (func == 6'b000100) || (func == 6'b001000) || (func == 6'b001001) ||
                    (func == 6'b000001) || (func == 6'b000000) || (func == 6'b000101) ||
                    (func == 6'b001010) || (func == 6'b001100);
        is_arith  = (func == 6'b010110) || (func == 6'b011001) || (func == 6'b110110);
        is_listed = is_logic || is_arith;
    end

    assert_n_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_listed |=> (flag_n == result[WIDTH-1]));

    assert_zero_detect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        is_listed |=> (flag_z == (result == '0)));

    assert_logic_holds_cv_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_logic |=> ($stable(flag_c) && $stable(flag_v)));

    assert_clear_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 6'b001100) |=> ((result == '0) && flag_z && !flag_n));

    assert_unlisted_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !is_listed |=> ((result == '0) && $stable({flag_n, flag_z, flag_c, flag_v})));

endmodule

bind fsel_alu fsel_alu_checker #(.WIDTH(WIDTH), .FS_W(FS_W)) u_fsel_alu_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .func   (func),
    .result (result),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .flag_c (flag_c),
    .flag_v (flag_v)
);

// File: tb/fsel_alu_test.sv
`timescale 1ns/1ps
// Bench for fsel_alu: behavioural per-clock reference model, inputs driven
// on falling edges, outputs compared on the following falling edge.
module fsel_alu_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic        carry_in;
    logic [5:0]  func;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_c, flag_v;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    // Model state: flags carried between operations.
    logic        m_n = 0, m_z = 0, m_c = 0, m_v = 0;
    logic [31:0] m_r = 0;

    always #2.5 clk = ~clk;

    fsel_alu uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .func(func), .result(result),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h (func=%b)", tag, what, act, exp, func);
        end
    endtask

    // Reference model update for one operation.
    task automatic model(input logic [31:0] a, input logic [31:0] b,
                         input logic ci, input logic [5:0] f, output string tag);
        logic [32:0] s;
        logic [31:0] x, y;
        bit arith = 0, listed = 1;
        tag = "R2";
        case (f)
            6'b000100: m_r = a & b;
            6'b001000: m_r = a & ~b;
            6'b001001: m_r = a ^ b;
            6'b000001: m_r = a | b;
            6'b000000: begin m_r = a;     tag = "R3"; end
            6'b000101: begin m_r = b;     tag = "R3"; end
            6'b001010: begin m_r = ~b;    tag = "R3"; end
            6'b001100: begin m_r = 32'd0; tag = "R3"; end
            6'b010110: begin x = a;  y = b;  arith = 1; end
            6'b011001: begin x = a;  y = ~b; arith = 1; end
            6'b110110: begin x = ~a; y = b;  arith = 1; end
            default:   begin listed = 0; m_r = 32'd0; tag = "R8"; end
        endcase
        if (arith) begin
            tag = "R4";
            s   = {1'b0, x} + {1'b0, y} + 33'(ci);
            m_r = s[31:0];
            m_c = s[32];
            m_v = (x[31] == y[31]) && (s[31] != x[31]);
        end
        if (listed) begin
            m_n = m_r[31];
            m_z = (m_r == 32'd0);
        end
    endtask

    // Drive one operation, then compare one edge later (R9 latency).
    task automatic step(input logic [31:0] a, input logic [31:0] b,
                        input logic ci, input logic [5:0] f);
        string tag;
        op_a = a; op_b = b; carry_in = ci; func = f;
        model(a, b, ci, f, tag);
        @(negedge clk);
        check({tag, "/R9"}, "result", result, m_r);
        check((tag == "R8") ? "R8" : "R5", "flag_n", 32'(flag_n), 32'(m_n));
        check((tag == "R8") ? "R8" : "R5", "flag_z", 32'(flag_z), 32'(m_z));
        check((tag == "R8") ? "R8" : "R6", "flag_c", 32'(flag_c), 32'(m_c));
        check((tag == "R8") ? "R8" : "R7", "flag_v", 32'(flag_v), 32'(m_v));
    endtask

    logic [5:0] codes [11] = '{6'b000100, 6'b001000, 6'b001001, 6'b000001,
                               6'b000000, 6'b000101, 6'b001010, 6'b001100,
                               6'b010110, 6'b011001, 6'b110110};

    function automatic bit listed_code(input logic [5:0] f);
        for (int i = 0; i < 11; i++) if (codes[i] == f) return 1;
        return 0;
    endfunction

    initial begin
        rst_n = 0; op_a = '1; op_b = '1; carry_in = 1; func = 6'b010110;
        @(negedge clk); @(negedge clk);
        // R1: reset clears result and flags.
        check("R1", "result", result, 32'd0);
        check("R1", "flags", 32'({flag_n, flag_z, flag_c, flag_v}), 32'd0);
        rst_n = 1;

        // R4 R6 R7 corners: overflow, carry out, zero sum.
        step(32'h7fffffff, 32'h00000001, 1'b0, 6'b010110);
        step(32'hffffffff, 32'h00000001, 1'b0, 6'b010110);
        step(32'h80000000, 32'h00000001, 1'b1, 6'b011001);
        step(32'h00000005, 32'h00000005, 1'b1, 6'b011001);
        step(32'h00000000, 32'h00000000, 1'b1, 6'b110110);
        // R6 R7: logic codes keep C and V from the arithmetic before.
        step(32'h7fffffff, 32'h00000001, 1'b0, 6'b010110);
        step(32'h12345678, 32'h0f0f0f0f, 1'b1, 6'b001001);
        step(32'h80000000, 32'h00000000, 1'b0, 6'b000000);
        // R3: clear code.
        step(32'hdeadbeef, 32'hcafef00d, 1'b1, 6'b001100);
        // R8: unlisted codes after flags are set by an arithmetic op.
        step(32'hffffffff, 32'h80000000, 1'b0, 6'b010110);
        step(32'h11111111, 32'h22222222, 1'b1, 6'b111111);
        step(32'h11111111, 32'h22222222, 1'b0, 6'b010111);

        // R2 R3 R4: every listed code over random operands and carry.
        for (int k = 0; k < 11; k++)
            for (int j = 0; j < 60; j++)
                step($urandom, $urandom, 1'($urandom), codes[k]);
        // Random mix, including unlisted codes.
        for (int j = 0; j < 2000; j++) begin
            logic [5:0] f = 6'($urandom);
            if (($urandom % 2) != 0) f = codes[$urandom % 11];
            step($urandom, $urandom, 1'($urandom), f);
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule